// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet FIFO

This block stores packets for a single endpoint in two equal buffers and hands them from producer to consumer without software involvement. For receive traffic (host to device) the USB side writes a packet into one buffer while the local CPU or DMA engine reads the previous packet from the other. For transmit traffic (device to host) the roles swap: the local side fills a buffer and the USB side reads it out when an IN token arrives. Each side switches to the other buffer on its own as it finishes with one.

Every buffer keeps its own byte count and valid flag. The block reports empty, full and last-byte status and a local service request, which the DMA and interrupt logic use. A transmit buffer is normally released to USB only once it is completely full. An end-of-transfer pulse from the local side releases a partly filled buffer early, and an isochronous endpoint also releases a partly filled buffer when an IN token arrives. A transmit buffer stays owned by USB until the host acknowledges it, so a failed transfer can be sent again.

Top module: `ep_dbuf_fifo`

## Requirements
- R1: After reset, empty_o=1, full_o=0, usb_tx_rdy_o=0 and loc_rdata_o=0. usb_rx_rdy_o=1 when cfg_dir_in_i=0. loc_req_o is 0 for the receive direction (cfg_dir_in_i=0) and 1 for the transmit direction (cfg_dir_in_i=1).
- R2: Each buffer holds 64 bytes when cfg_wide_i=0 and 128 bytes when cfg_wide_i=1. Received bytes beyond that capacity are dropped, and the stored count stops at the capacity.
- R3: Receive direction. A pulse on usb_start_i opens a packet and each usb_wr_i stores one byte. A pulse on usb_end_i commits a non-empty packet, raises loc_req_o and puts its byte count on loc_cnt_o. loc_rdata_o shows the next byte in write order and loc_rd_i consumes it. After the last byte is consumed, the block moves to the other buffer on its own.
- R4: Both buffers can hold packets at the same time, and full_o=1 when they do. While both buffers are full, the USB side is refused (usb_rx_rdy_o=0 for receive, loc_req_o=0 for transmit), and a packet sent by USB in that state is discarded.
- R5: Transmit direction without isochronous mode (cfg_iso_i=0). A buffer is offered to USB (usb_tx_rdy_o=1, usb_cnt_o=capacity) only on the local write that fills it. An IN token (usb_start_i) does not release a partly filled buffer.
- R6: Transmit direction. The offered buffer stays offered, with an unchanged usb_cnt_o, until usb_end_i acknowledges it. usb_start_i rewinds its read position to byte 0 so the packet can be sent again. After the acknowledgement the buffer is free for local writes.
- R7: Transmit direction. A pulse on loc_eot_i releases the current partly filled buffer to USB with its byte count.
- R8: Transmit direction with cfg_iso_i=1. usb_start_i releases a partly filled local buffer, which is offered from the next cycle.
- R9: When no received packet is held, a local read returns 0 and moves no pointer. The next packet committed afterwards is read from its first byte.
- R10: last_o=1 in the receive direction while loc_rdata_o shows the final byte of the current packet. In the transmit direction, last_o=1 when the buffer being filled has exactly one free byte left.
- R11: Receive direction. A usb_start_i pulse in the middle of a packet discards the bytes already stored for it, and the next commit holds only the bytes written after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dir_in_i | input | 1 | 1: transmit to host, 0: receive from host |
| cfg_iso_i | input | 1 | Isochronous endpoint |
| cfg_wide_i | input | 1 | 1: 128-byte buffers, 0: 64-byte buffers |
| usb_start_i | input | 1 | Packet start / IN token strobe |
| usb_end_i | input | 1 | Packet end / transfer acknowledged strobe |
| usb_wr_i | input | 1 | USB byte write |
| usb_wdata_i | input | 8 | USB write data |
| usb_rd_i | input | 1 | USB byte read (consume) |
| usb_rdata_o | output | 8 | USB read data, 0 when nothing is offered |
| usb_rx_rdy_o | output | 1 | A free buffer can accept a received packet |
| usb_tx_rdy_o | output | 1 | A packet is offered for transmission |
| usb_cnt_o | output | 8 | Byte count of the offered packet |
| loc_wr_i | input | 1 | Local byte write |
| loc_wdata_i | input | 8 | Local write data |
| loc_rd_i | input | 1 | Local byte read (consume) |
| loc_eot_i | input | 1 | End-of-transfer, releases a partial transmit buffer |
| loc_rdata_o | output | 8 | Local read data, 0 when empty |
| loc_req_o | output | 1 | Local service request (data to read or space to write) |
| loc_cnt_o | output | 8 | Receive: count of packet being read; transmit: bytes written so far |
| last_o | output | 1 | Last byte / last free slot indicator |
| full_o | output | 1 | Both buffers hold packets |
| empty_o | output | 1 | Neither buffer holds a packet |

## Verification
The assertions watch, on every cycle, the properties that relate status edges to their causes. A transmit buffer appears only through a fill or a release event, an offered buffer and its count stay put until acknowledged, a full receive endpoint stays full until a local read, and an empty local read yields zero. Byte ordering, the exact capacity switch between 64 and 128, the discard of a restarted or overflowing packet, and retransmission after a rewind all depend on data contents across whole packets, so only the bench scenarios show them.

// File: rtl/ep_dbuf_pkg.sv
package ep_dbuf_pkg;
  localparam int unsigned EP_DATA_W       = 8;
  localparam int unsigned EP_DEPTH_NARROW = 64;
  localparam int unsigned EP_DEPTH_WIDE   = 128;
  localparam int unsigned EP_NUM_BUF      = 2;

  typedef enum logic {
    BUF_A = 1'b0,
    BUF_B = 1'b1
  } buf_id_e;

  function automatic logic buf_flip(logic sel);
    return ~sel;
  endfunction
endpackage

// File: rtl/ep_dbuf_mem.sv
module ep_dbuf_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ep_dbuf_wr.sv
// Producer side: fills the selected buffer and closes it on full or on request.
module ep_dbuf_wr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cap_i,
  input  logic          auto_full_i,
  input  logic          wr_i,
  input  logic          restart_i,
  input  logic          close_req_i,
  input  logic [1:0]    valid_i,
  output logic          sel_o,
  output logic [CW-1:0] ptr_o,
  output logic          room_o,
  output logic          we_o,
  output logic          commit_o,
  output logic [CW-1:0] commit_cnt_o
);
  import ep_dbuf_pkg::*;

  logic          sel_q;
  logic [CW-1:0] ptr_q;
  logic          w_ok;
  logic [CW-1:0] n_next;

  assign room_o = ~valid_i[sel_q];
  assign w_ok   = wr_i & room_o & ~restart_i & (ptr_q < cap_i);
  assign n_next = ptr_q + CW'(w_ok);

  assign commit_o = room_o & ~restart_i &
                    ((auto_full_i & (n_next == cap_i)) |
                     (close_req_i & (n_next != '0)));
  assign commit_cnt_o = n_next;
  assign we_o         = w_ok;
  assign sel_o        = sel_q;
  assign ptr_o        = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= BUF_A;
      ptr_q <= '0;
    end else if (commit_o) begin
      sel_q <= buf_flip(sel_q);
      ptr_q <= '0;
    end else if (restart_i && room_o) begin
      ptr_q <= '0;
    end else if (w_ok) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/ep_dbuf_rd.sv
// Consumer side: drains the selected buffer, releases on last byte or on ack.
module ep_dbuf_rd #(
  parameter int unsigned CW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               auto_release_i,
  input  logic               rd_i,
  input  logic               rewind_i,
  input  logic               ack_i,
  input  logic [1:0]         valid_i,
  input  logic [1:0][CW-1:0] cnt_i,
  output logic               sel_o,
  output logic [CW-1:0]      ptr_o,
  output logic               have_o,
  output logic               in_range_o,
  output logic               last_o,
  output logic               release_o
);
  import ep_dbuf_pkg::*;

  logic          sel_q;
  logic [CW-1:0] ptr_q;
  logic [CW-1:0] cnt_sel;
  logic          r_ok;

  assign cnt_sel    = cnt_i[sel_q];
  assign have_o     = valid_i[sel_q];
  assign in_range_o = have_o & (ptr_q < cnt_sel);
  assign last_o     = in_range_o & (ptr_q == cnt_sel - 1'b1);
  assign r_ok       = rd_i & in_range_o & ~rewind_i;

  assign release_o = have_o & ((auto_release_i & r_ok & last_o) |
                               (~auto_release_i & ack_i));
  assign sel_o = sel_q;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= BUF_A;
      ptr_q <= '0;
    end else if (release_o) begin
      sel_q <= buf_flip(sel_q);
      ptr_q <= '0;
    end else if (rewind_i) begin
      ptr_q <= '0;
    end else if (r_ok) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/ep_dbuf_fifo.sv
module ep_dbuf_fifo
  import ep_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W       = EP_DATA_W,
  parameter int unsigned DEPTH_NARROW = EP_DEPTH_NARROW,
  parameter int unsigned DEPTH_WIDE   = EP_DEPTH_WIDE,
  localparam int unsigned AW          = $clog2(DEPTH_WIDE),
  localparam int unsigned CW          = $clog2(DEPTH_WIDE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_dir_in_i,
  input  logic              cfg_iso_i,
  input  logic              cfg_wide_i,
  input  logic              usb_start_i,
  input  logic              usb_end_i,
  input  logic              usb_wr_i,
  input  logic [DATA_W-1:0] usb_wdata_i,
  input  logic              usb_rd_i,
  output logic [DATA_W-1:0] usb_rdata_o,
  output logic              usb_rx_rdy_o,
  output logic              usb_tx_rdy_o,
  output logic [CW-1:0]     usb_cnt_o,
  input  logic              loc_wr_i,
  input  logic [DATA_W-1:0] loc_wdata_i,
  input  logic              loc_rd_i,
  input  logic              loc_eot_i,
  output logic [DATA_W-1:0] loc_rdata_o,
  output logic              loc_req_o,
  output logic [CW-1:0]     loc_cnt_o,
  output logic              last_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [CW-1:0] cap;
  assign cap = cfg_wide_i ? CW'(DEPTH_WIDE) : CW'(DEPTH_NARROW);

  logic [EP_NUM_BUF-1:0]         valid_q;
  logic [EP_NUM_BUF-1:0][CW-1:0] cnt_q;

  // Producer / consumer role mapping by direction
  logic              w_wr, w_restart, w_close;
  logic [DATA_W-1:0] w_data;
  logic              r_rd, r_rewind, r_ack;

  assign w_wr      = cfg_dir_in_i ? loc_wr_i : usb_wr_i;
  assign w_data    = cfg_dir_in_i ? loc_wdata_i : usb_wdata_i;
  assign w_restart = ~cfg_dir_in_i & usb_start_i;
  assign w_close   = cfg_dir_in_i ? (loc_eot_i | (cfg_iso_i & usb_start_i)) : usb_end_i;
  assign r_rd      = cfg_dir_in_i ? usb_rd_i : loc_rd_i;
  assign r_rewind  = cfg_dir_in_i & usb_start_i;
  assign r_ack     = cfg_dir_in_i & usb_end_i;

  logic          wr_sel, wr_room, wr_we, wr_commit;
  logic [CW-1:0] wr_ptr, wr_commit_cnt;
  logic          rd_sel, rd_have, rd_in_range, rd_last, rd_release;
  logic [CW-1:0] rd_ptr;

  ep_dbuf_wr #(.CW(CW)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_i        (cap),
    .auto_full_i  (cfg_dir_in_i),
    .wr_i         (w_wr),
    .restart_i    (w_restart),
    .close_req_i  (w_close),
    .valid_i      (valid_q),
    .sel_o        (wr_sel),
    .ptr_o        (wr_ptr),
    .room_o       (wr_room),
    .we_o         (wr_we),
    .commit_o     (wr_commit),
    .commit_cnt_o (wr_commit_cnt)
  );

  ep_dbuf_rd #(.CW(CW)) u_rd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .auto_release_i (~cfg_dir_in_i),
    .rd_i           (r_rd),
    .rewind_i       (r_rewind),
    .ack_i          (r_ack),
    .valid_i        (valid_q),
    .cnt_i          (cnt_q),
    .sel_o          (rd_sel),
    .ptr_o          (rd_ptr),
    .have_o         (rd_have),
    .in_range_o     (rd_in_range),
    .last_o         (rd_last),
    .release_o      (rd_release)
  );

  logic [EP_NUM_BUF-1:0][DATA_W-1:0] buf_rdata;

  for (genvar b = 0; b < EP_NUM_BUF; b++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[b] <= 1'b0;
        cnt_q[b]   <= '0;
      end else if (wr_commit && (wr_sel == 1'(b))) begin
        valid_q[b] <= 1'b1;
        cnt_q[b]   <= wr_commit_cnt;
      end else if (rd_release && (rd_sel == 1'(b))) begin
        valid_q[b] <= 1'b0;
      end
    end

    ep_dbuf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH_WIDE)) u_mem (
      .clk_i   (clk_i),
      .we_i    (wr_we && (wr_sel == 1'(b))),
      .waddr_i (wr_ptr[AW-1:0]),
      .wdata_i (w_data),
      .raddr_i (rd_ptr[AW-1:0]),
      .rdata_o (buf_rdata[b])
    );
  end

  logic [DATA_W-1:0] rd_data;
  assign rd_data = rd_in_range ? buf_rdata[rd_sel] : '0;

  assign usb_rdata_o  = cfg_dir_in_i ? rd_data : '0;
  assign loc_rdata_o  = cfg_dir_in_i ? '0 : rd_data;
  assign usb_tx_rdy_o = cfg_dir_in_i & rd_have;
  assign usb_rx_rdy_o = ~cfg_dir_in_i & wr_room;
  assign usb_cnt_o    = usb_tx_rdy_o ? cnt_q[rd_sel] : '0;
  assign loc_req_o    = cfg_dir_in_i ? wr_room : rd_have;
  assign loc_cnt_o    = cfg_dir_in_i ? wr_ptr : (rd_have ? cnt_q[rd_sel] : '0);
  assign last_o       = cfg_dir_in_i ? (wr_room & (wr_ptr == cap - 1'b1)) : rd_last;
  assign full_o       = &valid_q;
  assign empty_o      = ~|valid_q;
endmodule

// File: rtl/ep_dbuf_fifo_chk.sv
module ep_dbuf_fifo_chk #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned DEPTH_NARROW = 64,
  parameter int unsigned DEPTH_WIDE   = 128,
  localparam int unsigned CW          = $clog2(DEPTH_WIDE + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_dir_in_i,
  input logic              cfg_iso_i,
  input logic              cfg_wide_i,
  input logic              usb_end_i,
  input logic              usb_tx_rdy_o,
  input logic [CW-1:0]     usb_cnt_o,
  input logic              loc_rd_i,
  input logic              loc_eot_i,
  input logic [DATA_W-1:0] loc_rdata_o,
  input logic              loc_req_o,
  input logic              full_o,
  input logic              empty_o
);
  logic [CW-1:0] cap;
  assign cap = cfg_wide_i ? CW'(DEPTH_WIDE) : CW'(DEPTH_NARROW);

  a_r9_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_dir_in_i && empty_o) |-> (loc_rdata_o == '0));

  a_r5_full_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dir_in_i && !cfg_iso_i && $rose(usb_tx_rdy_o) && !$past(loc_eot_i))
      |-> (usb_cnt_o == cap));

  a_r7_partial_needs_eot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dir_in_i && !cfg_iso_i && $rose(usb_tx_rdy_o) && (usb_cnt_o != cap))
      |-> $past(loc_eot_i));

  a_r6_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dir_in_i && usb_tx_rdy_o && !usb_end_i) |=> (usb_tx_rdy_o && $stable(usb_cnt_o)));

  a_r4_full_until_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_dir_in_i && full_o && !loc_rd_i) |=> full_o);

  a_r3_req_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_dir_in_i && $rose(loc_req_o)) |-> $past(usb_end_i));

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_tx_rdy_o |-> ((usb_cnt_o != '0) && (usb_cnt_o <= cap)));
endmodule

bind ep_dbuf_fifo ep_dbuf_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH_NARROW(DEPTH_NARROW), .DEPTH_WIDE(DEPTH_WIDE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_dir_in_i (cfg_dir_in_i),
  .cfg_iso_i    (cfg_iso_i),
  .cfg_wide_i   (cfg_wide_i),
  .usb_end_i    (usb_end_i),
  .usb_tx_rdy_o (usb_tx_rdy_o),
  .usb_cnt_o    (usb_cnt_o),
  .loc_rd_i     (loc_rd_i),
  .loc_eot_i    (loc_eot_i),
  .loc_rdata_o  (loc_rdata_o),
  .loc_req_o    (loc_req_o),
  .full_o       (full_o),
  .empty_o      (empty_o)
);

// File: tb/ep_dbuf_fifo_tb.sv
module ep_dbuf_fifo_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_ni, cfg_dir_in_i, cfg_iso_i, cfg_wide_i;
  logic       usb_start_i, usb_end_i, usb_wr_i, usb_rd_i;
  logic [7:0] usb_wdata_i, usb_rdata_o;
  logic       usb_rx_rdy_o, usb_tx_rdy_o;
  logic [7:0] usb_cnt_o;
  logic       loc_wr_i, loc_rd_i, loc_eot_i;
  logic [7:0] loc_wdata_i, loc_rdata_o, loc_cnt_o;
  logic       loc_req_o, last_o, full_o, empty_o;

  ep_dbuf_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_dir_in_i(cfg_dir_in_i), .cfg_iso_i(cfg_iso_i),
    .cfg_wide_i(cfg_wide_i), .usb_start_i(usb_start_i), .usb_end_i(usb_end_i),
    .usb_wr_i(usb_wr_i), .usb_wdata_i(usb_wdata_i), .usb_rd_i(usb_rd_i),
    .usb_rdata_o(usb_rdata_o), .usb_rx_rdy_o(usb_rx_rdy_o), .usb_tx_rdy_o(usb_tx_rdy_o),
    .usb_cnt_o(usb_cnt_o), .loc_wr_i(loc_wr_i), .loc_wdata_i(loc_wdata_i),
    .loc_rd_i(loc_rd_i), .loc_eot_i(loc_eot_i), .loc_rdata_o(loc_rdata_o),
    .loc_req_o(loc_req_o), .loc_cnt_o(loc_cnt_o), .last_o(last_o),
    .full_o(full_o), .empty_o(empty_o)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  function automatic logic [7:0] pat(int base, int i);
    return 8'((base * 37 + i * 13 + 5) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    usb_start_i = 0; usb_end_i = 0; usb_wr_i = 0; usb_rd_i = 0; usb_wdata_i = 0;
    loc_wr_i = 0; loc_rd_i = 0; loc_eot_i = 0; loc_wdata_i = 0;
  endtask

  task automatic do_reset(bit dir_in, bit iso, bit wide);
    @(negedge clk);
    rst_ni = 0; cfg_dir_in_i = dir_in; cfg_iso_i = iso; cfg_wide_i = wide;
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic p_start(); @(negedge clk); usb_start_i = 1; @(negedge clk); usb_start_i = 0; endtask
  task automatic p_end();   @(negedge clk); usb_end_i = 1;   @(negedge clk); usb_end_i = 0;   endtask
  task automatic p_eot();   @(negedge clk); loc_eot_i = 1;   @(negedge clk); loc_eot_i = 0;   endtask

  task automatic usb_byte(logic [7:0] b);
    @(negedge clk); usb_wr_i = 1; usb_wdata_i = b; @(negedge clk); usb_wr_i = 0;
  endtask
  task automatic loc_byte(logic [7:0] b);
    @(negedge clk); loc_wr_i = 1; loc_wdata_i = b; @(negedge clk); loc_wr_i = 0;
  endtask
  task automatic loc_read(output logic [7:0] d);
    @(negedge clk); d = loc_rdata_o; loc_rd_i = 1; @(negedge clk); loc_rd_i = 0;
  endtask
  task automatic usb_read(output logic [7:0] d);
    @(negedge clk); d = usb_rdata_o; usb_rd_i = 1; @(negedge clk); usb_rd_i = 0;
  endtask

  task automatic usb_pkt(int len, int base);
    p_start();
    for (int i = 0; i < len; i++) usb_byte(pat(base, i));
    p_end();
  endtask

  task automatic drain_out(string req, int len, int base);
    logic [7:0] d;
    for (int i = 0; i < len; i++) begin
      chk({req, " R10 last"}, int'(last_o), (i == len - 1) ? 1 : 0);
      loc_read(d);
      chk({req, " data"}, int'(d), int'(pat(base, i)));
    end
  endtask

  task automatic drain_in(string req, int len, int base);
    logic [7:0] d;
    for (int i = 0; i < len; i++) begin
      usb_read(d);
      chk({req, " data"}, int'(d), int'(pat(base, i)));
    end
  endtask

  task automatic fill_in(int len, int base);
    for (int i = 0; i < len; i++) loc_byte(pat(base, i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int la, lb, ba, bb, sent;
    void'($urandom(32'd1234));
    rst_ni = 0; cfg_dir_in_i = 0; cfg_iso_i = 0; cfg_wide_i = 0;
    idle();

    // ---------------- receive, 64-byte buffers ----------------
    do_reset(0, 0, 0);
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 full", int'(full_o), 0);
    chk("R1 rx_rdy", int'(usb_rx_rdy_o), 1);
    chk("R1 tx_rdy", int'(usb_tx_rdy_o), 0);
    chk("R1 loc_req", int'(loc_req_o), 0);
    chk("R1 rdata", int'(loc_rdata_o), 0);

    loc_read(d);
    chk("R9 empty read data", int'(d), 0);
    chk("R9 still empty", int'(empty_o), 1);

    for (int k = 0; k < 12; k++) begin
      la = 1 + int'($urandom % 64); lb = 1 + int'($urandom % 64);
      ba = int'($urandom % 200); bb = int'($urandom % 200);
      sent = la;
      if (k == 0) begin la = 64; lb = 1; sent = 64; end
      if (k == 1) begin sent = 70; la = 64; end
      usb_pkt(sent, ba);
      chk("R3 loc_req", int'(loc_req_o), 1);
      chk("R2 R3 loc_cnt", int'(loc_cnt_o), la);
      chk("R4 not full", int'(full_o), 0);
      usb_pkt(lb, bb);
      chk("R4 full", int'(full_o), 1);
      chk("R4 rx refused", int'(usb_rx_rdy_o), 0);
      usb_pkt(3, 250);
      chk("R4 still full", int'(full_o), 1);
      drain_out("R3 pkt A", la, ba);
      chk("R3 switched cnt", int'(loc_cnt_o), lb);
      chk("R4 full cleared", int'(full_o), 0);
      drain_out("R3 pkt B", lb, bb);
      chk("R3 empty", int'(empty_o), 1);
    end

    p_start();
    for (int i = 0; i < 5; i++) usb_byte(pat(90, i));
    usb_pkt(3, 91);
    chk("R11 cnt", int'(loc_cnt_o), 3);
    drain_out("R11", 3, 91);

    loc_read(d);
    chk("R9 empty read", int'(d), 0);
    usb_pkt(2, 77);
    drain_out("R9 after empty", 2, 77);

    // ---------------- transmit, 64-byte buffers ----------------
    do_reset(1, 0, 0);
    chk("R1 in empty", int'(empty_o), 1);
    chk("R1 in loc_req", int'(loc_req_o), 1);
    chk("R1 in tx_rdy", int'(usb_tx_rdy_o), 0);
    fill_in(63, 10);
    chk("R10 one slot left", int'(last_o), 1);
    chk("R5 not offered", int'(usb_tx_rdy_o), 0);
    chk("R5 loc_cnt", int'(loc_cnt_o), 63);
    p_start();
    chk("R5 token no release", int'(usb_tx_rdy_o), 0);
    loc_byte(pat(10, 63));
    chk("R5 offered on fill", int'(usb_tx_rdy_o), 1);
    chk("R2 R5 cnt 64", int'(usb_cnt_o), 64);
    chk("R5 loc_req", int'(loc_req_o), 1);
    chk("R10 cleared", int'(last_o), 0);
    fill_in(64, 11);
    chk("R4 in full", int'(full_o), 1);
    chk("R4 in loc_req low", int'(loc_req_o), 0);
    drain_in("R6 first part", 10, 10);
    p_start();
    chk("R6 still offered", int'(usb_tx_rdy_o), 1);
    drain_in("R6 resend", 64, 10);
    p_end();
    chk("R6 next offered", int'(usb_tx_rdy_o), 1);
    chk("R6 freed", int'(loc_req_o), 1);
    chk("R6 full cleared", int'(full_o), 0);
    drain_in("R6 second buf", 64, 11);
    p_end();
    chk("R6 empty", int'(empty_o), 1);

    fill_in(10, 12);
    p_eot();
    chk("R7 offered", int'(usb_tx_rdy_o), 1);
    chk("R7 cnt", int'(usb_cnt_o), 10);
    drain_in("R7", 10, 12);
    p_end();
    for (int k = 0; k < 6; k++) begin
      la = 1 + int'($urandom % 63); ba = int'($urandom % 200);
      fill_in(la, ba);
      chk("R7 rnd hold", int'(usb_tx_rdy_o), 0);
      p_eot();
      chk("R7 rnd cnt", int'(usb_cnt_o), la);
      drain_in("R7 rnd", la, ba);
      p_end();
    end

    // ---------------- transmit, 128-byte buffers ----------------
    do_reset(1, 0, 1);
    fill_in(64, 20);
    chk("R2 wide not offered", int'(usb_tx_rdy_o), 0);
    for (int i = 64; i < 128; i++) loc_byte(pat(20, i));
    chk("R2 wide offered", int'(usb_tx_rdy_o), 1);
    chk("R2 wide cnt", int'(usb_cnt_o), 128);
    drain_in("R2 wide", 128, 20);
    p_end();

    // ---------------- isochronous transmit ----------------
    do_reset(1, 1, 1);
    fill_in(7, 30);
    chk("R8 before token", int'(usb_tx_rdy_o), 0);
    p_start();
    chk("R8 offered", int'(usb_tx_rdy_o), 1);
    chk("R8 cnt", int'(usb_cnt_o), 7);
    drain_in("R8", 7, 30);
    p_end();

    // ---------------- receive, 128-byte buffers ----------------
    do_reset(0, 1, 1);
    usb_pkt(128, 40);
    chk("R2 wide rx cnt", int'(loc_cnt_o), 128);
    drain_out("R2 wide rx", 128, 40);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule